// File: doc/BRIEF.md
# Bit-Serial Comb Cascade for a Decimating CIC Filter

This block is the comb half of a decimating CIC filter, built with bit-serial arithmetic. The integrator section runs at the fast clock. The comb section only has to produce one result per decimated sample. This block therefore spreads each comb subtraction over the many fast clocks that lie between two decimated samples, instead of building full-width parallel subtractors.

A parallel word from the last integrator is presented with a one-cycle strobe. The word is cut into groups of `B` bits and fed least significant group first through `N` cascaded serial subtractor stages, one group per clock. Each stage keeps its previous input sample in a `W`-bit serial delay line rather than in a parallel register. After the final stage, the groups are gathered back into a parallel word, which is presented with a one-cycle valid pulse.

The word width must not exceed the number of fast clocks per decimated sample multiplied by `B`. A `B` of 2 or 4 is chosen when the decimation ratio is too small for one bit per clock.

Top module: `serial_cic_comb`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `out_valid` is 0, `out_word` is 0 and `overrun` is 0. All stage history is cleared to zero.
- R2: Each output word is the N-th order backward difference, with differential delay 1, of the sequence of accepted input words. Samples before reset count as zero.
- R3: All arithmetic is modulo 2^W. It wraps around and never saturates; for example 0x0000 minus 0x0001 gives 0xFFFF at W=16.
- R4: Bits are processed least significant first, B per clock, over G = W/B clocks. `out_valid` is 1 in exactly the cycle that follows the (G+N)-th rising edge after the edge that accepted the strobe, and it is 1 for one cycle only.
- R5: `out_word` does not change in any cycle in which `out_valid` is 0.
- R6: A strobe is accepted when the block is idle or when the last group of the current word is being sent. Words spaced exactly G clocks apart all pass through and do not set `overrun`.
- R7: A strobe that arrives while a word is being serialized, other than on its last group, is ignored. That word never enters the difference history, and `overrun` is set.
- R8: `overrun` stays at 1 until reset, whatever later traffic arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_strobe | input | 1 | One-cycle strobe marking a new integrator word |
| in_word | input | W | Integrator output word, sampled with the strobe |
| out_word | output | W | Comb result of the most recent completed word |
| out_valid | output | 1 | One-cycle pulse when out_word is updated |
| overrun | output | 1 | Sticky flag: a strobe arrived while a word was still in flight |

## Verification
The acceptance test and the serializer's last-group shift can fall on the same clock edge. A strobe placed exactly G clocks after the previous one must reload the serializer while the last group of the old word leaves it. A strobe placed a few clocks earlier must instead be dropped and raise `overrun`. The bench provokes both spacings. It judges them by the output sequence, which must equal the N-th difference of the words it counts as accepted, and by the state of `overrun`. Any lost or doubled word shows up as a wrong difference in every later output.

// File: rtl/ccomb_pkg.sv
// Package: shared types for the bit-serial comb cascade.
// Assumes nothing beyond being compiled first.
package ccomb_pkg;

    // Framing flags that travel with every serial bit group.
    typedef struct packed {
        logic vld;    // a group is present this cycle
        logic first;  // least significant group of a word
        logic last;   // most significant group of a word
    } ccomb_tag_t;

endpackage

// File: rtl/ccomb_ser.sv
// Module: ccomb_ser
// Loads a parallel word on an accepted strobe and sends it out B bits per
// clock, least significant group first, with framing flags. A strobe is taken
// when idle or on the last group; otherwise it is dropped and flagged.
// Assumes W is a multiple of B and W/B >= 2.
module ccomb_ser
    import ccomb_pkg::*;
#(
    parameter int W = 16,
    parameter int B = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] word,
    output logic [B-1:0] bits_o,
    output ccomb_tag_t   tag_o,
    output logic         overrun_o
);
    localparam int G  = W / B;
    localparam int CW = (G > 1) ? $clog2(G) : 1;

    logic [W-1:0]  sreg;
    logic [CW-1:0] cnt;
    logic          busy;
    logic          last_grp;
    logic          take;

    assign last_grp = busy && (cnt == CW'(G - 1));
    assign take     = strobe && (!busy || last_grp);

    // Shift register and group counter for the word being sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (take) begin
            sreg <= word;
            cnt  <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            sreg <= sreg >> B;
            cnt  <= cnt + CW'(1);
            if (last_grp) busy <= 1'b0;
        end
    end

    // Sticky flag for a strobe that lands in the middle of a word.
    always_ff @(posedge clk) begin
        if (!rst_n)                           overrun_o <= 1'b0;
        else if (strobe && busy && !last_grp) overrun_o <= 1'b1;
    end

    assign bits_o      = sreg[B-1:0];
    assign tag_o.vld   = busy;
    assign tag_o.first = busy && (cnt == '0);
    assign tag_o.last  = last_grp;

endmodule

// File: rtl/ccomb_stage.sv
// Module: ccomb_stage
// One serial comb stage: out = x[n] - x[n-1] modulo 2^W, B bits per clock.
// The previous sample lives in a W-bit serial delay line; a borrow flop chains
// groups and is forced to the subtract start value on the first group.
// Assumes W is a multiple of B and W/B >= 2.
module ccomb_stage
    import ccomb_pkg::*;
#(
    parameter int W = 16,
    parameter int B = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [B-1:0] in_bits,
    input  ccomb_tag_t   in_tag,
    output logic [B-1:0] out_bits,
    output ccomb_tag_t   out_tag
);
    logic [W-1:0] dly;
    logic         carry_q;
    logic         cin;
    logic [B:0]   sum;

    // Group adder: in + ~delayed + carry, carry seeded to 1 on a first group.
    always_comb begin
        cin = in_tag.first ? 1'b1 : carry_q;
        sum = {1'b0, in_bits} + {1'b0, ~dly[B-1:0]} + (B+1)'(cin);
    end

    // Delay line, carry flop and registered result with its framing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly      <= '0;
            carry_q  <= 1'b0;
            out_bits <= '0;
            out_tag  <= '0;
        end else begin
            out_tag <= in_tag;
            if (in_tag.vld) begin
                dly      <= {in_bits, dly[W-1:B]};
                carry_q  <= sum[B];
                out_bits <= sum[B-1:0];
            end
        end
    end

endmodule

// File: rtl/ccomb_deser.sv
// Module: ccomb_deser
// Collects serial groups, least significant first, and loads the parallel
// output with a one-cycle valid when the last group arrives.
// Assumes W is a multiple of B and W/B >= 2.
module ccomb_deser
    import ccomb_pkg::*;
#(
    parameter int W = 16,
    parameter int B = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [B-1:0] in_bits,
    input  ccomb_tag_t   in_tag,
    output logic [W-1:0] out_word,
    output logic         out_valid
);
    logic [W-1:0] acc;
    logic [W-1:0] nxt;

    assign nxt = {in_bits, acc[W-1:B]};

    // Assembly register, output word and valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_tag.vld && in_tag.last;
            if (in_tag.vld) acc <= nxt;
            if (in_tag.vld && in_tag.last) out_word <= nxt;
        end
    end

endmodule

// File: rtl/serial_cic_comb.sv
// Module: serial_cic_comb
// Bit-serial comb cascade of a decimating CIC filter: serializer, N serial
// subtractor stages, deserializer. Latency from accepting edge to valid is
// W/B + N clocks. Assumes W is a multiple of B, W/B >= 2, and that strobes
// come no closer than W/B clocks apart.
module serial_cic_comb
    import ccomb_pkg::*;
#(
    parameter int W = 16,
    parameter int B = 2,
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_strobe,
    input  logic [W-1:0] in_word,
    output logic [W-1:0] out_word,
    output logic         out_valid,
    output logic         overrun
);
    logic [B-1:0] chain_bits [0:N];
    ccomb_tag_t   chain_tag  [0:N];

    ccomb_ser #(.W(W), .B(B)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (in_strobe),
        .word      (in_word),
        .bits_o    (chain_bits[0]),
        .tag_o     (chain_tag[0]),
        .overrun_o (overrun)
    );

    for (genvar gi = 0; gi < N; gi++) begin : g_stage
        ccomb_stage #(.W(W), .B(B)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_bits  (chain_bits[gi]),
            .in_tag   (chain_tag[gi]),
            .out_bits (chain_bits[gi+1]),
            .out_tag  (chain_tag[gi+1])
        );
    end

    ccomb_deser #(.W(W), .B(B)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_bits   (chain_bits[N]),
        .in_tag    (chain_tag[N]),
        .out_word  (out_word),
        .out_valid (out_valid)
    );

endmodule

// File: rtl/ccomb_chk.sv
// Module: ccomb_chk
// Property checker for serial_cic_comb, attached with bind below.
module ccomb_chk #(
    parameter int W = 16,
    parameter int B = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_strobe,
    input logic [W-1:0] out_word,
    input logic         out_valid,
    input logic         overrun,
    input logic         fin_vld,
    input logic         fin_last
);
    localparam int G = W / B;

    // R4: valid is a single-cycle pulse
    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (G > 1)) |=> !out_valid);

    // R4: valid only follows the last group leaving the final stage
    assert_valid_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(fin_vld && fin_last));

    // R5: output word holds when not valid
    assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_word));

    // R7: overrun only rises after a strobe
    assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(in_strobe));

    // R8: overrun is sticky
    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

bind serial_cic_comb ccomb_chk #(.W(W), .B(B)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_strobe (in_strobe),
    .out_word  (out_word),
    .out_valid (out_valid),
    .overrun   (overrun),
    .fin_vld   (chain_tag[N].vld),
    .fin_last  (chain_tag[N].last)
);

// File: tb/serial_cic_comb_tb.sv
module serial_cic_comb_tb;
    localparam int W = 16;
    localparam int B = 2;
    localparam int N = 5;
    localparam int G = W / B;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_strobe = 1'b0;
    logic [W-1:0] in_word = '0;
    logic [W-1:0] out_word;
    logic         out_valid;
    logic         overrun;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] hist [N];
    logic [W-1:0] expq [$];

    always #4 clk = ~clk;

    serial_cic_comb #(.W(W), .B(B), .N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_strobe(in_strobe), .in_word(in_word),
        .out_word(out_word), .out_valid(out_valid), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: N-th backward difference modulo 2^W
    task automatic model_push(input logic [W-1:0] x);
        logic [W-1:0] y, t;
        y = x;
        for (int s = 0; s < N; s++) begin
            t = y - hist[s];
            hist[s] = y;
            y = t;
        end
        expq.push_back(y);
    endtask

    // Output monitor: every valid word compared with the reference (R2, R3)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (expq.size() == 0) chk(1'b0, "R2 unexpected valid", out_word, '0);
            else begin
                logic [W-1:0] e;
                e = expq.pop_front();
                chk(out_word == e, "R2 R3 difference", out_word, e);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_strobe = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_word == '0 && overrun == 1'b0,
            "R1 in reset", {out_word[W-1:2], out_valid, overrun}, '0);
        for (int s = 0; s < N; s++) hist[s] = '0;
        expq.delete();
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_word == '0 && overrun == 1'b0,
            "R1 after release", {out_word[W-1:2], out_valid, overrun}, '0);
    endtask

    task automatic send(input logic [W-1:0] x, input bit accepted);
        @(negedge clk);
        in_word = x;
        in_strobe = 1'b1;
        if (accepted) model_push(x);
        @(negedge clk);
        in_strobe = 1'b0;
    endtask

    task automatic drain();
        repeat (G + N + 4) @(negedge clk);
        chk(expq.size() == 0, "R2 all outputs seen", W'(expq.size()), '0);
    endtask

    task automatic t_impulse();
        send(16'h0001, 1'b1);
        for (int i = 0; i < N + 2; i++) begin
            repeat (G + 2) @(negedge clk);
            send(16'h0000, 1'b1);
        end
        drain();
    endtask

    task automatic t_patterns();
        for (int i = 0; i < 8; i++) begin
            repeat (G) @(negedge clk);
            send(W'(i * 37 + 5), 1'b1);
        end
        for (int i = 0; i < 6; i++) begin
            repeat (G) @(negedge clk);
            send((i % 2) ? 16'hA5A5 : 16'h5A5A, 1'b1);
        end
        for (int i = 0; i < 10; i++) begin
            repeat (G) @(negedge clk);
            send(W'($urandom), 1'b1);
        end
        drain();
    endtask

    // R3: operands that force wraparound
    task automatic t_wrap();
        logic [W-1:0] vals [6] = '{16'hFFFF, 16'h0000, 16'h8000, 16'h7FFF, 16'hFFFF, 16'h0001};
        for (int i = 0; i < 6; i++) begin
            repeat (G) @(negedge clk);
            send(vals[i], 1'b1);
        end
        drain();
    endtask

    // R4: exact latency and one-cycle width of valid
    task automatic t_latency();
        int first_hi;
        int hi_count;
        first_hi = -1;
        hi_count = 0;
        @(negedge clk);
        in_word = 16'h1234;
        in_strobe = 1'b1;
        model_push(16'h1234);
        for (int j = 1; j <= G + N + 3; j++) begin
            @(negedge clk);
            in_strobe = 1'b0;
            if (out_valid) begin
                hi_count++;
                if (first_hi < 0) first_hi = j;
            end
        end
        chk(first_hi == G + N + 1, "R4 latency", W'(first_hi), W'(G + N + 1));
        chk(hi_count == 1, "R4 pulse width", W'(hi_count), W'(1));
        drain();
    endtask

    // R5: output word holds while idle
    task automatic t_hold();
        logic [W-1:0] held;
        bit ok;
        held = out_word;
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (out_word != held) ok = 1'b0;
        end
        chk(ok, "R5 hold", out_word, held);
    endtask

    // R6: back-to-back words exactly G clocks apart
    task automatic t_b2b();
        send(16'h0101, 1'b1);
        for (int i = 0; i < 6; i++) begin
            repeat (G - 2) @(negedge clk);
            send(W'(16'h0202 * (i + 2)), 1'b1);
        end
        drain();
        chk(overrun == 1'b0, "R6 no overrun at spacing G", W'(overrun), '0);
    endtask

    // R7, R8: a strobe mid-word is dropped and flagged
    task automatic t_overrun();
        send(16'h0F0F, 1'b1);
        @(negedge clk);
        send(16'hDEAD, 1'b0);
        @(negedge clk);
        chk(overrun == 1'b1, "R7 overrun set", W'(overrun), W'(1));
        drain();
        for (int i = 0; i < 3; i++) begin
            repeat (G) @(negedge clk);
            send(W'(16'h0033 + i), 1'b1);
        end
        drain();
        chk(overrun == 1'b1, "R8 overrun sticky", W'(overrun), W'(1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        t_impulse();
        t_patterns();
        t_wrap();
        t_latency();
        t_hold();
        t_b2b();
        t_overrun();
        do_reset();
        t_impulse();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule